// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is a serial slave for a two-wire control bus. It holds a bank of 9-bit control registers and presents their contents as parallel fields to the rest of the chip. Each write carries a 16-bit control word. The first data byte holds the 7-bit register address in its upper seven bits, and its lowest bit is bit 8 of the new value. The second data byte holds value bits 7..0. The slave answers to one of two 7-bit device addresses. An address-select input picks which one.

A read starts as a write that stops after the register-address byte. The master then issues a repeated start and the device address with the read bit set. The slave returns the low eight value bits first. If the master acknowledges, the slave then returns a byte of seven zeros followed by bit 8. The master ends the read with a NACK and a stop. Writing to register address 0x0F restores every register to its default value. The left/right input-volume registers and the left/right headphone-volume registers each accept a write with bit 8 set as a load into both channels at once. Two flags report when a headphone volume code falls in the mute range.

SCL and SDA are sampled with the system clock, which must run at least eight times faster than SCL. The pad is modelled only by a pull-low enable.

Top module: `ctl_i2c_regbank`

## Requirements
- R1: After reset, every register slot holds its default value and SDA is released. Slot k occupies bits 9k+8..9k of `reg_flat_o`. Slots 0..9 map to register addresses 0x00..0x09, and slots 10..12 map to addresses 0x10..0x12. The defaults are 0x097 for slots 0 and 1, 0x079 for slots 2 and 3, 0x09F for slot 6, 0x00A for slot 7, and 0 for all other slots.
- R2: The slave's device address is 0011010 when `addr_sel` is 0 and 0011011 when it is 1. A matching address byte with R/W=0 or R/W=1 is acknowledged by pulling SDA low during the ninth SCL pulse.
- R3: After a device address that does not match, the slave gives no acknowledge and changes no register until the next start condition.
- R4: In a write frame, data byte 1 bits 7..1 are the register address and bit 0 is value bit 8. Data byte 2 is value bits 7..0. The slave acknowledges each byte, and the addressed register then holds the 9-bit value.
- R5: After the register-address byte, a repeated start and a matching address with R/W=1 make the slave shift out value bits 7..0, MSB first. After a master ACK, the slave shifts out 0000000 followed by bit 8.
- R6: Writing to register address 0x0F returns every slot to its R1 default value.
- R7: A write to address 0x00 or 0x01 with bit 8 set stores the same 9-bit value in both slots 0 and 1. With bit 8 clear, only the addressed slot changes.
- R8: Addresses 0x02 and 0x03 pair in the same way as in R7, using slots 2 and 3.
- R9: `hp_mute_l_o` and `hp_mute_r_o` are high exactly when bits 6..0 of slot 2 or slot 3, respectively, are below 0110000.
- R10: Writes to unimplemented addresses (0x0A..0x0E and 0x13..0x7F) are acknowledged but change no slot. Reads from those addresses return 0.
- R11: A stop or start condition that arrives before the second data byte is complete aborts the frame, and no register changes.
- R12: Register slots change only in the cycle after the last bit of a write frame has been clocked in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (at least 8x SCL) |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_sel | input | 1 | Selects device address bit 0 |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | High to pull SDA low |
| reg_flat_o | output | 117 | All register slots, 9 bits each, slot k at bits 9k+8..9k |
| hp_mute_l_o | output | 1 | Left headphone volume code is in the mute range |
| hp_mute_r_o | output | 1 | Right headphone volume code is in the mute range |

## Verification
A bus edge reaches the byte engine two clocks after it appears at the pins. A committed write therefore shows on `reg_flat_o` and on the mute flags after the third rising clock edge that follows the SCL fall ending the last data bit. The bench's behavioural register model schedules each of its own updates three edges after that fall. It compares the whole register vector and both flags at every falling clock edge. Acknowledge and read-data bits are sampled halfway through the SCL high phase, well after the slave's three-clock drive latency following the previous SCL fall.

// File: rtl/ctl_i2c_pkg.sv
package ctl_i2c_pkg;

    localparam int DW        = 9;   // register width
    localparam int RAW       = 7;   // register address width
    localparam int NSLOT     = 13;  // implemented storage slots
    localparam int SYNC_LEN  = 2;   // synchroniser depth
    localparam int CNTW      = 4;   // bit counter width
    localparam int FLATW     = NSLOT * DW;
    localparam logic [RAW-1:0] SWRST_ADDR  = 7'h0F;
    localparam logic [6:0]     HP_MUTE_LIM = 7'b0110000;

    typedef enum logic [2:0] {
        S_IDLE, S_RX, S_RX_ACK, S_TX, S_TX_ACK
    } eng_st_e;

    typedef enum logic [1:0] {
        P_DEV, P_HI, P_LO, P_END
    } eng_ph_e;

    typedef struct packed {
        eng_st_e          st;
        eng_ph_e          ph;
        logic [CNTW-1:0]  cnt;
        logic [7:0]       sh;
        logic             rw;
        logic [RAW-1:0]   ptr;
        logic             hib8;
        logic             oe;
        logic             second;
        logic             mack;
    } eng_t;

    function automatic logic [DW-1:0] slot_default(input int k);
        case (k)
            0, 1:    return 9'h097;
            2, 3:    return 9'h079;
            6:       return 9'h09F;
            7:       return 9'h00A;
            default: return '0;
        endcase
    endfunction

    // Maps a register address to a storage slot, -1 when not implemented.
    function automatic int addr_to_slot(input logic [RAW-1:0] a);
        if (a <= 7'd9)                 return int'(a);
        if (a >= 7'h10 && a <= 7'h12)  return int'(a) - 6;
        return -1;
    endfunction

endpackage

// File: rtl/ctl_i2c_sync.sv
module ctl_i2c_sync
    import ctl_i2c_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    // Each line: SYNC_LEN stages plus one history stage for edge detection.
    logic [1:0]        pin;
    logic [SYNC_LEN:0] chain_q [2];
    logic [SYNC_LEN:0] chain_d [2];

    assign pin = {sda_i, scl_i};

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_line
            always_comb begin
                chain_d[g] = {chain_q[g][SYNC_LEN-1:0], pin[g]};
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= '1;
                else        chain_q[g] <= chain_d[g];
            end
        end
    endgenerate

    logic scl_p, sda_p;
    assign scl_s = chain_q[0][SYNC_LEN-1];
    assign scl_p = chain_q[0][SYNC_LEN];
    assign sda_s = chain_q[1][SYNC_LEN-1];
    assign sda_p = chain_q[1][SYNC_LEN];

    assign scl_rise  =  scl_s & ~scl_p;
    assign scl_fall  = ~scl_s &  scl_p;
    assign start_det =  scl_s &  scl_p &  sda_p & ~sda_s;
    assign stop_det  =  scl_s &  scl_p & ~sda_p &  sda_s;
endmodule

// File: rtl/ctl_i2c_engine.sv
module ctl_i2c_engine
    import ctl_i2c_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [6:0]     dev_addr,
    input  logic           sda_s,
    input  logic           scl_rise,
    input  logic           scl_fall,
    input  logic           start_det,
    input  logic           stop_det,
    input  logic [DW-1:0]  rd_data,
    output logic [RAW-1:0] ptr_o,
    output logic           wr_en_o,
    output logic [DW-1:0]  wr_data_o,
    output logic           sda_oe
);
    eng_t q, n;

    always_comb begin
        n       = q;
        wr_en_o = 1'b0;
        if (stop_det) begin
            n.st = S_IDLE;
            n.oe = 1'b0;
        end else if (start_det) begin
            n.st  = S_RX;
            n.ph  = P_DEV;
            n.cnt = '0;
            n.oe  = 1'b0;
        end else begin
            unique case (q.st)
                S_RX: begin
                    if (scl_rise && q.cnt != CNTW'(8)) begin
                        n.sh  = {q.sh[6:0], sda_s};
                        n.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == CNTW'(8)) begin
                        n.cnt = '0;
                        unique case (q.ph)
                            P_DEV: begin
                                if (q.sh[7:1] == dev_addr) begin
                                    n.st = S_RX_ACK;
                                    n.oe = 1'b1;
                                    n.rw = q.sh[0];
                                    n.ph = P_HI;
                                end else begin
                                    n.st = S_IDLE;
                                end
                            end
                            P_HI: begin
                                n.ptr  = q.sh[7:1];
                                n.hib8 = q.sh[0];
                                n.st   = S_RX_ACK;
                                n.oe   = 1'b1;
                                n.ph   = P_LO;
                            end
                            P_LO: begin
                                wr_en_o = 1'b1;
                                n.st    = S_RX_ACK;
                                n.oe    = 1'b1;
                                n.ph    = P_END;
                            end
                            default: n.st = S_IDLE;
                        endcase
                    end
                end
                S_RX_ACK: begin
                    if (scl_fall) begin
                        n.oe = 1'b0;
                        if (q.ph == P_END) begin
                            n.st = S_IDLE;
                        end else if (q.ph == P_HI && q.rw) begin
                            n.st     = S_TX;
                            n.sh     = rd_data[7:0];
                            n.oe     = ~rd_data[7];
                            n.second = 1'b0;
                            n.cnt    = '0;
                        end else begin
                            n.st = S_RX;
                        end
                    end
                end
                S_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == CNTW'(7)) begin
                            n.oe = 1'b0;
                            n.st = S_TX_ACK;
                        end else begin
                            n.sh  = {q.sh[6:0], 1'b0};
                            n.oe  = ~q.sh[6];
                            n.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                S_TX_ACK: begin
                    if (scl_rise) n.mack = ~sda_s;
                    if (scl_fall) begin
                        if (q.mack && !q.second) begin
                            n.st     = S_TX;
                            n.second = 1'b1;
                            n.sh     = {7'b0, rd_data[8]};
                            n.oe     = 1'b1;
                            n.cnt    = '0;
                        end else begin
                            n.st = S_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, ph: P_DEV, cnt: '0, sh: '0, rw: 1'b0,
                   ptr: '0, hib8: 1'b0, oe: 1'b0, second: 1'b0, mack: 1'b0};
        end else begin
            q <= n;
        end
    end

    assign ptr_o     = q.ptr;
    assign wr_data_o = {q.hib8, q.sh};
    assign sda_oe    = q.oe;
endmodule

// File: rtl/ctl_i2c_regfile.sv
module ctl_i2c_regfile
    import ctl_i2c_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [RAW-1:0]   addr,
    input  logic [DW-1:0]    wr_data,
    output logic [DW-1:0]    rd_data,
    output logic [FLATW-1:0] flat_o,
    output logic             mute_l_o,
    output logic             mute_r_o
);
    logic [DW-1:0] regs_q [NSLOT];
    logic [DW-1:0] regs_d [NSLOT];
    int            slot;

    always_comb begin
        slot = addr_to_slot(addr);
        for (int k = 0; k < NSLOT; k++) regs_d[k] = regs_q[k];
        if (wr_en) begin
            if (addr == SWRST_ADDR) begin
                for (int k = 0; k < NSLOT; k++) regs_d[k] = slot_default(k);
            end else if (slot >= 0) begin
                regs_d[slot] = wr_data;
                // volume pairs 0/1 and 2/3 load both channels on bit 8
                if (slot < 4 && wr_data[DW-1]) regs_d[slot ^ 1] = wr_data;
            end
        end
        rd_data = (slot >= 0) ? regs_q[slot] : '0;
    end

    genvar g;
    generate
        for (g = 0; g < NSLOT; g++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) regs_q[g] <= slot_default(g);
                else        regs_q[g] <= regs_d[g];
            end
            assign flat_o[g*DW +: DW] = regs_q[g];
        end
    endgenerate

    assign mute_l_o = regs_q[2][6:0] < HP_MUTE_LIM;
    assign mute_r_o = regs_q[3][6:0] < HP_MUTE_LIM;
endmodule

// File: rtl/ctl_i2c_regbank.sv
module ctl_i2c_regbank
    import ctl_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_BASE = 7'b0011010
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr_sel,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    output logic [FLATW-1:0] reg_flat_o,
    output logic             hp_mute_l_o,
    output logic             hp_mute_r_o
);
    logic           scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic           wr_en;
    logic [RAW-1:0] wr_addr;
    logic [DW-1:0]  wr_data, rd_data;
    logic [6:0]     dev_addr;

    assign dev_addr = DEV_BASE | {6'b0, addr_sel};

    ctl_i2c_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    ctl_i2c_engine u_eng (
        .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .rd_data(rd_data), .ptr_o(wr_addr),
        .wr_en_o(wr_en), .wr_data_o(wr_data), .sda_oe(sda_oe)
    );

    ctl_i2c_regfile u_rf (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(wr_addr),
        .wr_data(wr_data), .rd_data(rd_data), .flat_o(reg_flat_o),
        .mute_l_o(hp_mute_l_o), .mute_r_o(hp_mute_r_o)
    );
endmodule

// File: rtl/ctl_i2c_regbank_chk.sv
module ctl_i2c_regbank_chk
    import ctl_i2c_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             scl_s,
    input logic             start_det,
    input logic             sda_oe,
    input logic             wr_en,
    input logic [RAW-1:0]   wr_addr,
    input logic [DW-1:0]    wr_data,
    input logic [FLATW-1:0] reg_flat
);
    // R12: slots hold unless a write frame just completed
    a_r12_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(reg_flat));

    // R6: software reset address restores defaults
    a_r6_sw_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == SWRST_ADDR) |=>
            (reg_flat[0 +: DW] == 9'h097 && reg_flat[6*DW +: DW] == 9'h09F));

    // R7: left input volume with bit 8 also loads the right slot
    a_r7_input_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 7'h00 && wr_data[DW-1]) |=>
            (reg_flat[1*DW +: DW] == $past(wr_data)));

    // R8: right headphone volume with bit 8 also loads the left slot
    a_r8_hp_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 7'h03 && wr_data[DW-1]) |=>
            (reg_flat[2*DW +: DW] == $past(wr_data)));

    // R2: the slave only starts pulling SDA while SCL is low
    a_r2_drive_on_low_scl: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // R11: a start condition releases the data line
    a_r11_release_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);
endmodule

bind ctl_i2c_regbank ctl_i2c_regbank_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .reg_flat(reg_flat_o)
);

// File: tb/ctl_i2c_regbank_tb.sv
module ctl_i2c_regbank_tb;
    localparam int NS = 13;
    localparam int FW = NS * 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          addr_sel = 1'b0;
    logic          scl = 1'b1;
    logic          m_sda = 1'b1;
    logic          sda_oe;
    logic          sda_line;
    logic [FW-1:0] reg_flat_o;
    logic          hp_mute_l_o, hp_mute_r_o;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;
    bit cmp_on = 0;

    logic [8:0] model [NS];
    int         pend_cnt = 0;
    logic [6:0] pend_addr;
    logic [8:0] pend_data;

    always #5 clk = ~clk;
    assign sda_line = m_sda & ~sda_oe;

    ctl_i2c_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .scl_i(scl),
        .sda_i(sda_line), .sda_oe(sda_oe), .reg_flat_o(reg_flat_o),
        .hp_mute_l_o(hp_mute_l_o), .hp_mute_r_o(hp_mute_r_o)
    );

    function automatic logic [8:0] dflt(input int k);
        if (k <= 1) return 9'h097;
        if (k <= 3) return 9'h079;
        if (k == 6) return 9'h09F;
        if (k == 7) return 9'h00A;
        return 9'h000;
    endfunction

    function automatic int slot_of(input logic [6:0] a);
        if (a < 7'd10) return int'(a);
        if (a >= 7'h10 && a <= 7'h12) return int'(a) - 6;
        return -1;
    endfunction

    task automatic model_reset();
        for (int k = 0; k < NS; k++) model[k] = dflt(k);
    endtask

    task automatic model_write(input logic [6:0] a, input logic [8:0] d);
        int s;
        s = slot_of(a);
        if (a == 7'h0F) model_reset();
        else if (s >= 0) begin
            model[s] = d;
            if (s < 4 && d[8]) begin
                if (s % 2 == 0) model[s+1] = d;
                else            model[s-1] = d;
            end
        end
    endtask

    function automatic logic [8:0] model_read(input logic [6:0] a);
        int s;
        s = slot_of(a);
        return (s >= 0) ? model[s] : 9'h000;
    endfunction

    // apply scheduled model updates three clock edges after the final SCL fall
    always @(posedge clk) begin
        if (pend_cnt > 0) begin
            pend_cnt = pend_cnt - 1;
            if (pend_cnt == 0) model_write(pend_addr, pend_data);
        end
    end

    // every-clock comparison (R4 R7 R8 R9 R10 R11 R12)
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            logic [FW-1:0] ef;
            logic ml, mr;
            for (int k = 0; k < NS; k++) ef[k*9 +: 9] = model[k];
            ml = model[2][6:0] < 7'h30;
            mr = model[3][6:0] < 7'h30;
            compared++;
            if (reg_flat_o !== ef || hp_mute_l_o !== ml || hp_mute_r_o !== mr) begin
                mismatched++;
                $display("FAIL R12 model compare: act %h/%b%b exp %h/%b%b",
                         reg_flat_o, hp_mute_l_o, hp_mute_r_o, ef, ml, mr);
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: act %0h exp %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(4); scl = 1'b1; tick(8);
        m_sda = 1'b0; tick(8); scl = 1'b0; tick(4);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(4); scl = 1'b1; tick(8);
        m_sda = 1'b1; tick(8);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nb);
        for (int i = 7; i > 7 - nb; i--) begin
            m_sda = b[i]; tick(4); scl = 1'b1; tick(8); scl = 1'b0; tick(4);
        end
    endtask

    // one written byte; optional model commit scheduled at the last SCL fall
    task automatic send_byte(input logic [7:0] b, input bit commit,
                             input logic [6:0] ca, input logic [8:0] cd,
                             output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(4); scl = 1'b1; tick(8); scl = 1'b0;
            if (i == 0 && commit) begin
                pend_addr = ca; pend_data = cd; pend_cnt = 3;
            end
            tick(4);
        end
        m_sda = 1'b1; tick(4); scl = 1'b1; tick(4);
        ack = (sda_line == 1'b0);
        tick(4); scl = 1'b0; tick(4);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; tick(4); scl = 1'b1; tick(4);
            v[i] = sda_line; tick(4); scl = 1'b0; tick(4);
        end
        m_sda = give_ack ? 1'b0 : 1'b1;
        tick(4); scl = 1'b1; tick(8); scl = 1'b0; tick(4);
        m_sda = 1'b1;
    endtask

    task automatic reg_write(input logic [6:0] dev, input logic [6:0] a,
                             input logic [8:0] d, input bit exp_ack);
        bit ak;
        bus_start();
        send_byte({dev, 1'b0}, 0, a, d, ak);
        check("R2 address ack", int'(ak), int'(exp_ack));
        send_byte({a, d[8]}, 0, a, d, ak);
        check("R4 first data byte ack", int'(ak), int'(exp_ack));
        send_byte(d[7:0], exp_ack, a, d, ak);
        check("R4 second data byte ack", int'(ak), int'(exp_ack));
        bus_stop();
        tick(4);
    endtask

    task automatic reg_read(input logic [6:0] dev, input logic [6:0] a,
                            output logic [7:0] lo, output logic [7:0] hi);
        bit ak;
        bus_start();
        send_byte({dev, 1'b0}, 0, a, 9'h0, ak);
        check("R5 read setup address ack", int'(ak), 1);
        send_byte({a, 1'b0}, 0, a, 9'h0, ak);
        check("R5 register address ack", int'(ak), 1);
        bus_start();
        send_byte({dev, 1'b1}, 0, a, 9'h0, ak);
        check("R2 read address ack", int'(ak), 1);
        recv_byte(1'b1, lo);
        recv_byte(1'b0, hi);
        bus_stop();
        tick(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [7:0] lo, hi;
        bit ak;
        model_reset();
        tick(5);
        rst_n = 1'b1;
        tick(3);
        cmp_on = 1;

        // R1 reset state
        check("R1 sda released", int'(sda_oe), 0);
        check("R1 slot0 default", int'(reg_flat_o[0 +: 9]), 'h097);
        check("R1 slot3 default", int'(reg_flat_o[27 +: 9]), 'h079);
        check("R1 slot6 default", int'(reg_flat_o[54 +: 9]), 'h09F);
        check("R1 slot7 default", int'(reg_flat_o[63 +: 9]), 'h00A);
        check("R1 slot12 default", int'(reg_flat_o[108 +: 9]), 0);

        // R4 plain write and R5 read back
        reg_write(7'h1A, 7'h05, 9'h1A5, 1);
        check("R4 slot5 value", int'(reg_flat_o[45 +: 9]), 'h1A5);
        reg_read(7'h1A, 7'h05, lo, hi);
        check("R5 low byte", int'(lo), 'hA5);
        check("R5 high byte", int'(hi), 'h01);
        reg_write(7'h1A, 7'h11, 9'h0C3, 1);
        reg_read(7'h1A, 7'h11, lo, hi);
        check("R5 low byte slot11", int'(lo), 'hC3);
        check("R5 high byte slot11", int'(hi), 'h00);

        // R7 input volume pair
        reg_write(7'h1A, 7'h00, 9'h12C, 1);
        check("R7 left slot", int'(reg_flat_o[0 +: 9]), 'h12C);
        check("R7 right copy", int'(reg_flat_o[9 +: 9]), 'h12C);
        reg_write(7'h1A, 7'h01, 9'h055, 1);
        check("R7 right only", int'(reg_flat_o[9 +: 9]), 'h055);
        check("R7 left kept", int'(reg_flat_o[0 +: 9]), 'h12C);

        // R8 headphone pair, R9 mute flags
        reg_write(7'h1A, 7'h03, 9'h130, 1);
        check("R8 left copy", int'(reg_flat_o[18 +: 9]), 'h130);
        check("R9 code 0110000 not muted", int'(hp_mute_l_o), 0);
        reg_write(7'h1A, 7'h02, 9'h02F, 1);
        check("R9 code 0101111 muted", int'(hp_mute_l_o), 1);
        check("R8 right kept", int'(reg_flat_o[27 +: 9]), 'h130);
        check("R9 right not muted", int'(hp_mute_r_o), 0);

        // R10 unimplemented addresses
        reg_write(7'h1A, 7'h0A, 9'h155, 1);
        reg_write(7'h1A, 7'h13, 9'h1FF, 1);
        reg_read(7'h1A, 7'h0A, lo, hi);
        check("R10 read unimplemented low", int'(lo), 0);
        check("R10 read unimplemented high", int'(hi), 0);

        // R3 address mismatch: no ack, nothing written
        bus_start();
        send_byte({7'h1B, 1'b0}, 0, 7'h0, 9'h0, ak);
        check("R3 no ack on wrong address", int'(ak), 0);
        send_byte({7'h05, 1'b1}, 0, 7'h0, 9'h0, ak);
        check("R3 no ack later byte", int'(ak), 0);
        send_byte(8'hFF, 0, 7'h0, 9'h0, ak);
        bus_stop();
        tick(4);
        check("R3 slot5 unchanged", int'(reg_flat_o[45 +: 9]), 'h1A5);

        // R11 abort by stop and by start in the middle of the value byte
        bus_start();
        send_byte({7'h1A, 1'b0}, 0, 7'h0, 9'h0, ak);
        send_byte({7'h05, 1'b0}, 0, 7'h0, 9'h0, ak);
        send_bits(8'h3C, 4);
        bus_stop();
        tick(4);
        check("R11 stop abort", int'(reg_flat_o[45 +: 9]), 'h1A5);
        bus_start();
        send_byte({7'h1A, 1'b0}, 0, 7'h0, 9'h0, ak);
        send_byte({7'h05, 1'b0}, 0, 7'h0, 9'h0, ak);
        send_bits(8'h00, 6);
        bus_start();
        bus_stop();
        tick(4);
        check("R11 start abort", int'(reg_flat_o[45 +: 9]), 'h1A5);

        // R2 alternate device address
        addr_sel = 1'b1;
        tick(4);
        reg_write(7'h1B, 7'h08, 9'h0A1, 1);
        check("R2 sel=1 write", int'(reg_flat_o[72 +: 9]), 'h0A1);
        reg_write(7'h1A, 7'h08, 9'h111, 0);
        check("R2 sel=1 old address ignored", int'(reg_flat_o[72 +: 9]), 'h0A1);

        // R6 software reset
        reg_write(7'h1B, 7'h0F, 9'h000, 1);
        check("R6 slot0 restored", int'(reg_flat_o[0 +: 9]), 'h097);
        check("R6 slot2 restored", int'(reg_flat_o[18 +: 9]), 'h079);
        check("R6 slot5 restored", int'(reg_flat_o[45 +: 9]), 0);
        check("R6 mute cleared", int'(hp_mute_l_o), 0);

        tick(10);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule